// File: doc/BRIEF.md
# Lock-Aware PLL Post Divider

This block sits in the fast oscillator domain of a clock generator. It produces two single-cycle clock-enable pulses from the VCO clock. The first, `pll_en`, marks each edge of the derived PLL output clock. The second, `bus_en`, marks each edge of the bus clock, which always runs at half the PLL output rate. The division ratio comes from a 5-bit divide setting held in an 8-bit register. While the PLL reports lock, the ratio is setting plus one. While lock is absent, the block falls back to a fixed divide by four, whatever the setting holds.

Software updates the setting through a one-cycle write strobe with data. The write is accepted only while the PLL is the selected clock source; otherwise it is silently dropped. The register can be read at any time.

The lock input comes from another domain, so it passes through a two-flop synchronizer before it steers the ratio. A ratio change, whether from a write or from a change of lock, is applied only when the divider reaches its terminal count. The period in progress always completes at its old length.

Top module: `pll_postdiv_gen`

## Requirements
- R1: After reset the readback `div_rdata` is 0x03. Bits 7:5 of `div_rdata` always read 0, and bits 7:5 of a written value are discarded.
- R2: A write (`wr_en`=1) with `pll_sel`=1 stores `wr_data[4:0]`. The new value appears on `div_rdata` in the cycle after the write edge.
- R3: A write with `pll_sel`=0 has no effect: `div_rdata` and the output period are unchanged.
- R4: While the synchronized lock is 1, `pll_en` pulses once every setting+1 VCO cycles. A setting of 0 gives a pulse on every cycle.
- R5: While the synchronized lock is 0, `pll_en` pulses once every 4 VCO cycles, whatever the setting.
- R6: `bus_en` is only ever asserted together with `pll_en`, and it is asserted on every second `pll_en`. Its period is therefore twice the `pll_en` period.
- R7: A new ratio takes effect only at a terminal count. After a setting change in mid-period, the running interval keeps its old length and the next interval uses the new ratio.
- R8: While `rst_n` is 0, neither `pll_en` nor `bus_en` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | Fast VCO reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lock_in | input | 1 | PLL lock status, asynchronous to clk_vco |
| pll_sel | input | 1 | 1 when the PLL is the selected system clock source; gates writes |
| wr_en | input | 1 | One-cycle write strobe for the divide setting |
| wr_data | input | 8 | Write data; bits 4:0 are the divide setting |
| pll_en | output | 1 | Single-cycle enable for the PLL output clock domain |
| bus_en | output | 1 | Single-cycle enable for the bus clock domain |
| div_rdata | output | 8 | Readback of the divide setting; bits 7:5 are zero |

## Verification
The hardest situation to reach from the ports is a setting change that lands inside a long divide period. The design must finish that period at its old length and only then switch. The bench sets up the longest ratio (32 cycles), waits for a `pll_en` pulse, and writes a setting of 0 on the very next cycle. It then measures the interval still running and the one after it. Lock fallback is reached by dropping `lock_in` while a non-fallback setting is stored, so the divide-by-four period must come from the lock path and not from the register.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  localparam int SET_W        = 5;  // divide setting width
  localparam int REG_W        = 8;  // register readback width
  localparam int SET_RST      = 3;  // setting value after reset
  localparam int FALLBACK_M1  = 3;  // terminal value while unlocked (divide by 4)
  localparam int SYNC_STAGES  = 2;  // lock synchronizer depth
endpackage

// File: rtl/pdiv_sync.sv
module pdiv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pdiv_setreg.sv
module pdiv_setreg #(
  parameter int W   = 5,
  parameter int RW  = 8,
  parameter int RST = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          pll_sel,
  input  logic [RW-1:0] wr_data,
  output logic [W-1:0]  setting,
  output logic [RW-1:0] rdata
);
  localparam int PAD = RW - W;

  logic [W-1:0] set_q;
  logic [W-1:0] set_d;
  logic         wr_ok;
  logic         unused_hi;

  assign wr_ok     = wr_en & pll_sel;
  assign unused_hi = ^wr_data[RW-1:W];

  always_comb begin
    set_d = set_q;
    if (wr_ok) set_d = wr_data[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) set_q <= W'(RST);
    else        set_q <= set_d;
  end

  assign setting = set_q;
  assign rdata   = {{PAD{1'b0}}, set_q};
endmodule

// File: rtl/pdiv_core.sv
module pdiv_core #(
  parameter int W  = 5,
  parameter int FB = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lock_s,
  input  logic [W-1:0] setting,
  output logic         pll_en,
  output logic         bus_en
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         ph_q, ph_d;
  logic         run_q, run_d;
  logic [W-1:0] lim;
  logic         tc;

  // ratio is sampled only at terminal count, so a running period is never cut short
  assign lim = lock_s ? setting : W'(FB);
  assign tc  = run_q & (cnt_q == '0);

  always_comb begin
    run_d = 1'b1;
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (run_q) begin
      if (tc) begin
        cnt_d = lim;
        ph_d  = ~ph_q;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign pll_en = tc;
  assign bus_en = tc & ph_q;
endmodule

// File: rtl/pll_postdiv_gen.sv
module pll_postdiv_gen
  import pdiv_pkg::*;
#(
  parameter int SW  = SET_W,
  parameter int RW  = REG_W,
  parameter int RST = SET_RST,
  parameter int FB  = FALLBACK_M1,
  parameter int SYN = SYNC_STAGES
) (
  input  logic          clk_vco,
  input  logic          rst_n,
  input  logic          lock_in,
  input  logic          pll_sel,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_data,
  output logic          pll_en,
  output logic          bus_en,
  output logic [RW-1:0] div_rdata
);
  logic          rst_sync_n;
  logic          lock_s;
  logic [SW-1:0] setting;

  // reset: asserted asynchronously, released on the VCO clock
  pdiv_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk_vco), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  pdiv_sync #(.STAGES(SYN)) u_lock_sync (
    .clk(clk_vco), .rst_n(rst_sync_n), .d(lock_in), .q(lock_s)
  );

  pdiv_setreg #(.W(SW), .RW(RW), .RST(RST)) u_setreg (
    .clk(clk_vco), .rst_n(rst_sync_n), .wr_en(wr_en), .pll_sel(pll_sel),
    .wr_data(wr_data), .setting(setting), .rdata(div_rdata)
  );

  pdiv_core #(.W(SW), .FB(FB)) u_core (
    .clk(clk_vco), .rst_n(rst_sync_n), .lock_s(lock_s), .setting(setting),
    .pll_en(pll_en), .bus_en(bus_en)
  );
endmodule

// File: rtl/pdiv_chk.sv
module pdiv_chk #(
  parameter int SW = 5,
  parameter int RW = 8
) (
  input logic          clk_vco,
  input logic          rst_n,
  input logic          pll_sel,
  input logic          wr_en,
  input logic [RW-1:0] wr_data,
  input logic          pll_en,
  input logic          bus_en,
  input logic [RW-1:0] div_rdata
);
  // R8: no enables while reset is held
  a_r8_quiet_reset: assert property (@(posedge clk_vco)
    !rst_n |-> (!pll_en && !bus_en));

  // R6: bus enable only together with a PLL enable
  a_r6_bus_inside_pll: assert property (@(posedge clk_vco) disable iff (!rst_n)
    bus_en |-> pll_en);

  // R2: accepted write is visible on the readback next cycle
  a_r2_write_lands: assert property (@(posedge clk_vco) disable iff (!rst_n)
    (wr_en && pll_sel && $past(rst_n)) |=> (div_rdata[SW-1:0] == $past(wr_data[SW-1:0])));

  // R3: rejected write leaves the readback untouched
  a_r3_write_dropped: assert property (@(posedge clk_vco) disable iff (!rst_n)
    (wr_en && !pll_sel && $past(rst_n)) |=> $stable(div_rdata));
endmodule

bind pll_postdiv_gen pdiv_chk #(.SW(SW), .RW(RW)) u_chk (
  .clk_vco(clk_vco), .rst_n(rst_n), .pll_sel(pll_sel), .wr_en(wr_en),
  .wr_data(wr_data), .pll_en(pll_en), .bus_en(bus_en), .div_rdata(div_rdata)
);

// File: tb/tb_pll_postdiv_gen.sv
module tb_pll_postdiv_gen;
  localparam int CLK_P = 10;
  localparam int NV    = 8;

  logic       clk_vco = 1'b0;
  logic       rst_n   = 1'b0;
  logic       lock_in = 1'b1;
  logic       pll_sel = 1'b1;
  logic       wr_en   = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       pll_en, bus_en;
  logic [7:0] div_rdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk_vco = ~clk_vco;

  pll_postdiv_gen dut (
    .clk_vco(clk_vco), .rst_n(rst_n), .lock_in(lock_in), .pll_sel(pll_sel),
    .wr_en(wr_en), .wr_data(wr_data), .pll_en(pll_en), .bus_en(bus_en),
    .div_rdata(div_rdata)
  );

  // {sel, data, lock, expected readback, expected pll period}
  typedef struct packed {
    logic       sel;
    logic [7:0] data;
    logic       lock;
    logic [7:0] rd;
    logic [7:0] per;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h03, 1'b1, 8'h03, 8'd4},   // R4 reset value ratio
    '{1'b1, 8'h00, 1'b1, 8'h00, 8'd1},   // R4 divide by one
    '{1'b1, 8'h01, 1'b1, 8'h01, 8'd2},   // R4
    '{1'b1, 8'h1F, 1'b1, 8'h1F, 8'd32},  // R4 max
    '{1'b0, 8'h05, 1'b1, 8'h1F, 8'd32},  // R3 dropped write
    '{1'b1, 8'h07, 1'b0, 8'h07, 8'd4},   // R5 unlocked fallback
    '{1'b1, 8'hEA, 1'b1, 8'h0A, 8'd11},  // R1 upper bits discarded
    '{1'b1, 8'h00, 1'b0, 8'h00, 8'd4}    // R5 fallback over zero
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic sel, input logic [7:0] d);
    @(negedge clk_vco);
    pll_sel = sel; wr_en = 1'b1; wr_data = d;
    @(negedge clk_vco);
    wr_en = 1'b0; pll_sel = 1'b1;
  endtask

  task automatic wait_pll;
    do @(negedge clk_vco); while (!pll_en);
  endtask

  task automatic gap_pll(output int g);
    g = 0;
    do begin @(negedge clk_vco); g++; end while (!pll_en);
  endtask

  task automatic gap_bus(output int g);
    do @(negedge clk_vco); while (!bus_en);
    g = 0;
    do begin @(negedge clk_vco); g++; end while (!bus_en);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_vco);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int g;
    // R8 and R1: reset state
    repeat (5) @(negedge clk_vco);
    check("R8 pll_en in reset", int'(pll_en), 0);
    check("R1 readback after reset", int'(div_rdata), 8'h03);
    rst_n = 1'b1;
    repeat (6) @(negedge clk_vco);

    for (int i = 0; i < NV; i++) begin
      do_write(VECS[i].sel, VECS[i].data);
      lock_in = VECS[i].lock;
      check("R1/R2/R3 readback", int'(div_rdata), int'(VECS[i].rd));
      repeat (40) @(negedge clk_vco);
      wait_pll();
      gap_pll(g);
      check("R4/R5 pll period", g, int'(VECS[i].per));
      gap_bus(g);
      check("R6 bus period", g, 2 * int'(VECS[i].per));
    end

    // R7: mid-period change from 31 to 0 keeps the running 32-cycle interval
    lock_in = 1'b1;
    do_write(1'b1, 8'h1F);
    repeat (40) @(negedge clk_vco);
    wait_pll();
    pll_sel = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
    @(negedge clk_vco);
    wr_en = 1'b0;
    g = 1;
    while (!pll_en) begin @(negedge clk_vco); g++; end
    check("R7 running interval kept", g, 32);
    gap_pll(g);
    check("R7 next interval new ratio", g, 1);

    finish_run();
  end
endmodule